// File: doc/BRIEF.md
# Step/Direction Microstep Phase Generator

This block converts a step pulse and a direction level into a microstep position within one electrical cycle. From that position it produces two drive magnitudes, one following a sine and one a cosine, and each has its own sign bit. A downstream current regulator uses these values as its set-points for the two motor windings. Every rising step edge moves the position by an amount set by the resolution code. Direction and resolution are captured at that same edge, so a change to either affects only the next step.

The step, direction, resolution, enable and fault pins are brought into the system clock domain through two-flop synchronizers. An enable level gates the drive outputs. The position counter keeps tracking steps while the outputs are gated off. A fault input sets a sticky flag that holds the drive off until reset. An asynchronous active-low reset returns the position to home. In the home state phase A is at zero and phase B is at full scale.

Top module: `microstep_phase_gen`

## Requirements
- R1: While `rst_n` is low, `pos_out` is 0, `drive_on` is 0, both magnitudes are 0 and both sign bits are 0. After release with enable high and no fault, the outputs show `a_mag` = 0, `b_mag` = 255 and both signs 0.
- R2: Each rising edge on `step_in` changes `pos_out` exactly once, modulo 1024. The count goes up when the captured direction is 1 and down when it is 0.
- R3: The captured resolution code selects the step size: code 0 is 64 counts, 1 is 32, 2 is 16, 3 is 8 and 4 is 4. Codes 5, 6 and 7 also give 4 counts.
- R4: Direction and resolution are sampled only at a rising step edge. If they change while the step level is steady, the position does not move, and the next rising edge uses the new values.
- R5: Let W(p) = floor(255·16·p·(512−p) / (5·512² − 4·p·(512−p))) for p in 0..256. With m = pos mod 512, `a_mag` is W(m) for m ≤ 256 and W(512−m) otherwise, and `a_neg` = 1 when pos ≥ 512. `b_mag` and `b_neg` follow the same rule applied to (pos+256) mod 1024.
- R6: While `enable_in` is low, `drive_on` is 0 and both magnitudes and both sign bits are 0. Steps received during that time still move `pos_out`.
- R7: A high level on `fault_in` sets `fault_flag`. The flag stays set after `fault_in` returns low, and it forces the drive outputs off even when enable is high.
- R8: Reset clears `fault_flag`. If `fault_in` is still high when reset is released, the flag sets again.
- R9: A step pulse with 75 ns high and 75 ns low counts exactly once. A step held high for a long time also counts exactly once. A 500 ns reset pulse gives a full return to home.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step pulse; a rising edge moves the position |
| dir_in | input | 1 | Direction; 1 counts up, 0 counts down |
| res_in | input | 3 | Resolution code (0 full step .. 4 sixteenth step) |
| enable_in | input | 1 | Drive enable; tie high when unused |
| fault_in | input | 1 | Fault request; sets the sticky fault flag |
| pos_out | output | 10 | Microstep position within the electrical cycle |
| a_mag | output | 8 | Phase A magnitude (sine) |
| a_neg | output | 1 | Phase A sign, 1 = negative |
| b_mag | output | 8 | Phase B magnitude (cosine) |
| b_neg | output | 1 | Phase B sign, 1 = negative |
| drive_on | output | 1 | Drive outputs active |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
The hardest case to reach from the ports is a direction and resolution change that arrives while the step level is held steady. That change must have no effect until a later rising edge. The stimulus holds `step_in` high past the synchronizer delay, changes both controls, and waits. It then drops the step and checks that the position has not moved. Only after that does it issue a new edge and check that this step uses the new size and sense. The second hard case is a fault that is still asserted when reset is released. This is reached by holding `fault_in` high across a full 500 ns reset pulse.

// File: rtl/usp_pkg.sv
`timescale 1ns/1ps
package usp_pkg;

  // Size of one step in position counts for a resolution code.
  // Codes above max_code are clamped to the finest resolution.
  function automatic int unsigned step_count(input logic [2:0] code,
                                             input int unsigned full,
                                             input int unsigned max_code);
    int unsigned sh;
    sh = (int'(code) > int'(max_code)) ? max_code : int'(code);
    return full >> sh;
  endfunction

  // Rational sine approximation over a half wave of 2*2^q_w points,
  // scaled to the full range of amp_w bits.
  function automatic longint wave_level(input longint p, input int q_w, input int amp_w);
    longint n, t, top;
    n   = 2 * (longint'(1) << q_w);
    t   = p * (n - p);
    top = (longint'(1) << amp_w) - 1;
    return (16 * t * top) / (5 * n * n - 4 * t);
  endfunction

endpackage

// File: rtl/usp_sync.sv
`timescale 1ns/1ps
module usp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= INIT;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/usp_step_counter.sv
`timescale 1ns/1ps
module usp_step_counter
  import usp_pkg::*;
#(
  parameter int unsigned POS_W    = 10,
  parameter int unsigned RES_W    = 3,
  parameter int unsigned FULL     = 64,
  parameter int unsigned MAX_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_s,
  input  logic             dir_s,
  input  logic [RES_W-1:0] res_s,
  output logic [POS_W-1:0] pos,
  output logic             step_rise,
  output logic             step_pend
);
  logic             step_d;
  logic             dir_q;
  logic [RES_W-1:0] res_q;
  logic [POS_W-1:0] inc;

  assign step_rise = step_s & ~step_d;
  assign inc       = POS_W'(step_count(3'(res_q), FULL, MAX_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_d    <= 1'b0;
      step_pend <= 1'b0;
      dir_q     <= 1'b0;
      res_q     <= '0;
      pos       <= '0;
    end else begin
      step_d    <= step_s;
      step_pend <= step_rise;
      if (step_rise) begin
        dir_q <= dir_s;
        res_q <= res_s;
      end
      if (step_pend) pos <= dir_q ? pos + inc : pos - inc;
    end
  end

  AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pend |=> $stable(pos)); // R2
  AST_CTRL_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_rise |=> ($stable(dir_q) && $stable(res_q))); // R4
  AST_UP_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pend && dir_q) |=> $onehot(POS_W'(pos - $past(pos)))); // R3
  AST_DOWN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pend && !dir_q) |=> $onehot(POS_W'($past(pos) - pos))); // R3
endmodule

// File: rtl/usp_quarter_wave.sv
`timescale 1ns/1ps
module usp_quarter_wave
  import usp_pkg::*;
#(
  parameter int unsigned POS_W = 10,
  parameter int unsigned AMP_W = 8
) (
  input  logic [POS_W-1:0] pos,
  output logic [AMP_W-1:0] mag,
  output logic             neg
);
  localparam int unsigned Q_W   = POS_W - 2;
  localparam int unsigned DEPTH = 1 << Q_W;
  localparam logic [AMP_W-1:0] PEAK = '1;

  logic [AMP_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = AMP_W'(wave_level(longint'(i), Q_W, AMP_W));
  end

  logic [1:0]     quad;
  logic [Q_W-1:0] q;

  always_comb begin
    quad = pos[POS_W-1 -: 2];
    q    = pos[Q_W-1:0];
    neg  = quad[1];
    if (!quad[0])     mag = rom[q];
    else if (q == '0) mag = PEAK;
    else              mag = rom[Q_W'(DEPTH - int'(q))];
  end
endmodule

// File: rtl/microstep_phase_gen.sv
`timescale 1ns/1ps
module microstep_phase_gen #(
  parameter int unsigned POS_W    = 10,
  parameter int unsigned AMP_W    = 8,
  parameter int unsigned RES_W    = 3,
  parameter int unsigned MAX_CODE = 4,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [RES_W-1:0] res_in,
  input  logic             enable_in,
  input  logic             fault_in,
  output logic [POS_W-1:0] pos_out,
  output logic [AMP_W-1:0] a_mag,
  output logic             a_neg,
  output logic [AMP_W-1:0] b_mag,
  output logic             b_neg,
  output logic             drive_on,
  output logic             fault_flag
);
  localparam int unsigned FULL    = 1 << (POS_W - 4);
  localparam int unsigned IN_W    = RES_W + 4;
  localparam logic [POS_W-1:0] QUARTER = POS_W'(1 << (POS_W - 2));
  localparam logic [AMP_W-1:0] PEAK    = '1;

  logic [IN_W-1:0] raw_in, syn_in;
  logic             step_s, dir_s, en_s, fault_s;
  logic [RES_W-1:0] res_s;

  assign raw_in = {res_in, fault_in, enable_in, dir_in, step_in};

  usp_sync #(.W(IN_W), .STAGES(SYNC_N), .INIT('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

  assign {res_s, fault_s, en_s, dir_s, step_s} = syn_in;

  logic step_rise, step_pend;
  logic [POS_W-1:0] pos;

  usp_step_counter #(.POS_W(POS_W), .RES_W(RES_W), .FULL(FULL), .MAX_CODE(MAX_CODE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_s(step_s), .dir_s(dir_s), .res_s(res_s),
    .pos(pos), .step_rise(step_rise), .step_pend(step_pend));

  logic [POS_W-1:0] pos_b;
  logic [AMP_W-1:0] sin_mag, cos_mag;
  logic             sin_neg, cos_neg;

  assign pos_b = pos + QUARTER;

  usp_quarter_wave #(.POS_W(POS_W), .AMP_W(AMP_W)) u_wave_a (
    .pos(pos), .mag(sin_mag), .neg(sin_neg));
  usp_quarter_wave #(.POS_W(POS_W), .AMP_W(AMP_W)) u_wave_b (
    .pos(pos_b), .mag(cos_mag), .neg(cos_neg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_flag <= 1'b0;
    else if (fault_s) fault_flag <= 1'b1;
  end

  assign drive_on = en_s & ~fault_flag;
  assign pos_out  = pos;
  assign a_mag    = drive_on ? sin_mag : '0;
  assign b_mag    = drive_on ? cos_mag : '0;
  assign a_neg    = drive_on & sin_neg;
  assign b_neg    = drive_on & cos_neg;

  always @(posedge clk) begin
    if (!rst_n) AST_HOME_IN_RESET: assert (pos_out == '0 && !drive_on && a_mag == '0 && b_mag == '0); // R1
  end
  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_on |-> (a_mag == '0 && b_mag == '0 && !a_neg && !b_neg)); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |=> fault_flag); // R7
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> !drive_on); // R7
  AST_AXIS_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_on && pos[POS_W-3:0] == '0) |->
      ((a_mag == '0 && b_mag == PEAK) || (a_mag == PEAK && b_mag == '0))); // R5
  AST_EDGE_THEN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    step_rise |=> step_pend); // R2
endmodule

// File: tb/sim_microstep_phase_gen.sv
`timescale 1ns/1ps
module sim_microstep_phase_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0, dir_in = 1'b1, enable_in = 1'b1, fault_in = 1'b0;
  logic [2:0] res_in = 3'd0;
  logic [9:0] pos_out;
  logic [7:0] a_mag, b_mag;
  logic       a_neg, b_neg, drive_on, fault_flag;

  int checks = 0;
  int errors = 0;
  int exp_pos = 0;
  bit done = 0;

  always #5 clk = ~clk;

  microstep_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in), .res_in(res_in),
    .enable_in(enable_in), .fault_in(fault_in), .pos_out(pos_out), .a_mag(a_mag),
    .a_neg(a_neg), .b_mag(b_mag), .b_neg(b_neg), .drive_on(drive_on), .fault_flag(fault_flag));

  function automatic int level(input int p);
    longint x, y, t;
    x = p; y = 512 - p; t = x * y;
    return int'((t * 4080) / (1310720 - 4 * t));
  endfunction

  function automatic int amp_of(input int ps);
    int m;
    m = ps % 512;
    return (m <= 256) ? level(m) : level(512 - m);
  endfunction

  function automatic int size_of(input int code);
    return (code >= 4) ? 4 : 64 / (1 << code);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_step();
    step_in = 1'b1; #75;
    step_in = 1'b0; #75;
    settle(3);
  endtask

  task automatic check_wave(input string req);
    int pb;
    pb = (exp_pos + 256) % 1024;
    check({req, " pos"}, int'(pos_out), exp_pos);
    check({req, " a_mag"}, int'(a_mag), amp_of(exp_pos));
    check({req, " a_neg"}, int'(a_neg), (exp_pos >= 512) ? 1 : 0);
    check({req, " b_mag"}, int'(b_mag), amp_of(pb));
    check({req, " b_neg"}, int'(b_neg), (pb >= 512) ? 1 : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; #250;
    check("R1 pos in reset", int'(pos_out), 0);
    check("R1 drive_on in reset", int'(drive_on), 0);
    check("R1 mags in reset", int'(a_mag) + int'(b_mag), 0);
    check("R1 signs in reset", int'(a_neg) + int'(b_neg), 0);
    #250; rst_n = 1'b1;
    exp_pos = 0;
    settle(5);
  endtask

  task automatic t_reset_home();
    do_reset();
    check("R9 R1 drive_on after release", int'(drive_on), 1);
    check_wave("R1 home");
    check("R1 home b_mag full", int'(b_mag), 255);
  endtask

  task automatic t_count_up();
    dir_in = 1'b1;
    for (int c = 0; c < 8; c++) begin
      res_in = 3'(c); #40;
      pulse_step();
      exp_pos = (exp_pos + size_of(c)) % 1024;
      check_wave("R3 R5 up step");
    end
    res_in = 3'd0;
    for (int k = 0; k < 18; k++) begin
      pulse_step();
      exp_pos = (exp_pos + 64) % 1024;
      check_wave("R2 R5 full step sweep");
    end
  endtask

  task automatic t_count_down();
    do_reset();
    dir_in = 1'b0; res_in = 3'd1; #40;
    for (int k = 0; k < 5; k++) begin
      pulse_step();
      exp_pos = (exp_pos + 1024 - 32) % 1024;
      check_wave("R2 down step wrap");
    end
  endtask

  task automatic t_latch();
    dir_in = 1'b1; res_in = 3'd2; #40;
    step_in = 1'b1; settle(8);
    exp_pos = (exp_pos + 16) % 1024;
    check("R4 step with first settings", int'(pos_out), exp_pos);
    dir_in = 1'b0; res_in = 3'd0;
    settle(10);
    check("R4 no move on ctrl change while high", int'(pos_out), exp_pos);
    step_in = 1'b0; settle(10);
    check("R4 no move on falling edge", int'(pos_out), exp_pos);
    pulse_step();
    exp_pos = (exp_pos + 1024 - 64) % 1024;
    check_wave("R4 next edge uses new settings");
  endtask

  task automatic t_enable();
    enable_in = 1'b0; settle(4);
    check("R6 drive_on low", int'(drive_on), 0);
    dir_in = 1'b1; res_in = 3'd3; #40;
    for (int k = 0; k < 3; k++) begin
      pulse_step();
      exp_pos = (exp_pos + 8) % 1024;
      check("R6 pos counts while disabled", int'(pos_out), exp_pos);
      check("R6 mags off", int'(a_mag) + int'(b_mag), 0);
      check("R6 signs off", int'(a_neg) + int'(b_neg), 0);
    end
    enable_in = 1'b1; settle(4);
    check("R6 drive back on", int'(drive_on), 1);
    check_wave("R6 resume");
  endtask

  task automatic t_fault();
    fault_in = 1'b1; #30; fault_in = 1'b0;
    settle(5);
    check("R7 flag set", int'(fault_flag), 1);
    check("R7 drive off", int'(drive_on), 0);
    settle(20);
    check("R7 flag sticky", int'(fault_flag), 1);
    check("R7 mags off", int'(a_mag) + int'(b_mag), 0);
    do_reset();
    check("R8 flag cleared", int'(fault_flag), 0);
    check("R8 drive on after clear", int'(drive_on), 1);
    fault_in = 1'b1;
    do_reset();
    check("R8 flag sets again if fault held", int'(fault_flag), 1);
    fault_in = 1'b0;
    do_reset();
    check("R8 flag clear after cause removed", int'(fault_flag), 0);
  endtask

  task automatic t_hold();
    dir_in = 1'b1; res_in = 3'd4; #40;
    step_in = 1'b1; settle(60);
    exp_pos = (exp_pos + 4) % 1024;
    check("R9 long high counts once", int'(pos_out), exp_pos);
    step_in = 1'b0; settle(5);
    for (int k = 0; k < 6; k++) pulse_step();
    exp_pos = (exp_pos + 24) % 1024;
    check("R9 min width pulses each count", int'(pos_out), exp_pos);
  endtask

  initial begin
    t_reset_home();
    t_count_up();
    t_count_down();
    t_latch();
    t_enable();
    t_fault();
    t_hold();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule